// File: doc/BRIEF.md
# Handshaked SPI Slave Frame Engine

This block is the slave end of a full-duplex serial link that uses two ready lines in place of a chip select. The master drives a master-ready input. The block answers on a slave-ready output. Every exchange is one fixed-length frame: a 4-byte header followed by a payload whose byte count is a parameter and a multiple of four. The block shifts a prepared outgoing frame onto MISO while it captures the incoming frame from MOSI. The header meaning and the buffers live outside the block. A byte-address port fetches outgoing bytes from the local source, and a byte strobe hands each received byte to the local sink.

All serial inputs are synchronized into the system clock domain, and the serial clock edges are found there. Because of this, the system clock must run at least eight times faster than the serial clock. An idle engine starts a frame on a rising edge of master-ready, or on a local transmit request once the master has clocked at least one frame since reset. It loads the first outgoing byte and then raises slave-ready. Frame end is found by counting serial clock falls. After each frame, slave-ready stays low for a minimum time. A continue input then decides whether the block prepares another frame or goes back to idle. If the serial clock stalls partway through a frame for longer than a timeout, the frame is abandoned.

Top module: `hs_spi_slave_frame`

## Requirements
- R1: MISO changes only on serial clock rises, and MOSI is captured on serial clock falls. Each byte travels most significant bit first. MISO is held high whenever slave-ready is low.
- R2: A frame is FRAME_BYTES = 4 + PAYLOAD_BYTES bytes long. Frame end is reached after exactly 8*FRAME_BYTES serial clock falls. Received bytes are emitted on rx_valid_o with addresses 0 to FRAME_BYTES-1 in order. Outgoing bytes are fetched at tx_addr_o 0 to FRAME_BYTES-1 in order. A normal end gives one frame_done_o pulse with frame_ok_o = 1.
- R3: From idle, a rising edge of master-ready prepares the frame and then raises slave-ready. A master-ready level that stays high without a new rising edge does not start a frame.
- R4: Slave-ready falls at frame end, in the same cycle as frame_done_o. The block raises it again without a new request only if cont_i is 1 when the minimum low time ends. If cont_i is 0, the block returns to idle.
- R5: Master-ready is ignored while a frame is running. Dropping it mid-frame neither aborts nor shortens the frame.
- R6: If no serial clock edge arrives for TIMEOUT_CYCLES system cycles during a frame, the frame is abandoned. Slave-ready falls. timeout_o pulses for exactly one cycle, together with frame_done_o and frame_ok_o = 0. The block returns to idle regardless of cont_i. The next frame transmits again from byte address 0.
- R7: Once lowered, slave-ready stays low for at least SRDY_LOW_CYCLES system cycles before it rises again.
- R8: tx_req_i starts a frame from idle only after the master has clocked at least one frame since reset. Before that, it has no effect on slave-ready.
- R9: If master-ready is already high when reset is released, the block starts a frame with no further edge.
- R10: During reset, slave-ready is low, MISO is high, and frame_done_o and timeout_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | Serial clock from the master, idles low |
| spi_mosi_i | input | 1 | Serial data from the master |
| spi_miso_o | output | 1 | Serial data to the master, idles high |
| mrdy_i | input | 1 | Master-ready line |
| srdy_o | output | 1 | Slave-ready line |
| tx_req_i | input | 1 | Local request to send a frame |
| cont_i | input | 1 | Continue condition, sampled when the post-frame low time ends |
| tx_byte_i | input | 8 | Outgoing byte at address tx_addr_o |
| tx_addr_o | output | clog2(FRAME_BYTES+1) | Address of the next outgoing byte |
| tx_take_o | output | 1 | Pulse: tx_byte_i was latched |
| rx_byte_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Pulse: rx_byte_o is valid |
| rx_addr_o | output | clog2(FRAME_BYTES) | Position of rx_byte_o within the frame |
| frame_done_o | output | 1 | Pulse: frame finished or was abandoned |
| frame_ok_o | output | 1 | With frame_done_o: 1 when the frame completed normally |
| timeout_o | output | 1 | One-cycle pulse on a stalled-clock abort |

## Verification
Assertions check the following on every cycle: MISO is high whenever slave-ready is low, slave-ready drops together with frame_done_o, slave-ready obeys the minimum low time, timeout_o is a single-cycle pulse that always comes with a failed frame_done_o, and the final received byte comes with the end-of-frame marker. Only the bench scenarios can show the rest. These are the serialized byte values in both directions, the handshake that starts a frame from an edge but not from a level, the continue decision, the gating of local requests before the first master frame, a mid-frame master-ready drop, the start when master-ready is high as reset releases, and the restart from byte zero after a stall.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
   localparam int HDR_BYTES = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PREP,
      ST_READY,
      ST_XFER,
      ST_GAP
   } hsf_state_e;
endpackage

// File: rtl/hsf_sync.sv
module hsf_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hsf_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_i};
   end

   assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/hsf_datapath.sv
module hsf_datapath #(
   parameter  int FRAME_BYTES = 2048,
   localparam int FRAME_BITS  = FRAME_BYTES * 8,
   localparam int BITW        = $clog2(FRAME_BITS),
   localparam int TXAW        = $clog2(FRAME_BYTES + 1),
   localparam int RXAW        = $clog2(FRAME_BYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            abort_i,
   input  logic            rise_i,
   input  logic            fall_i,
   input  logic            mosi_i,
   input  logic [7:0]      tx_byte_i,
   output logic [TXAW-1:0] tx_addr_o,
   output logic            tx_take_o,
   output logic            miso_o,
   output logic [7:0]      rx_byte_o,
   output logic            rx_valid_o,
   output logic [RXAW-1:0] rx_addr_o,
   output logic            last_o
);
   logic [7:0]      tx_sr;
   logic [7:0]      rx_sr;
   logic [2:0]      tx_bit;
   logic [2:0]      rx_bit;
   logic [BITW-1:0] bit_cnt;
   logic [RXAW-1:0] rx_idx;
   logic            fetch_ok;
   logic            is_last;

   assign fetch_ok = tx_addr_o < TXAW'(FRAME_BYTES);
   assign is_last  = bit_cnt == BITW'(FRAME_BITS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr      <= '0;
         rx_sr      <= '0;
         tx_bit     <= '0;
         rx_bit     <= '0;
         bit_cnt    <= '0;
         rx_idx     <= '0;
         tx_addr_o  <= '0;
         tx_take_o  <= 1'b0;
         miso_o     <= 1'b1;
         rx_byte_o  <= '0;
         rx_valid_o <= 1'b0;
         rx_addr_o  <= '0;
         last_o     <= 1'b0;
      end else begin
         tx_take_o  <= 1'b0;
         rx_valid_o <= 1'b0;
         last_o     <= 1'b0;
         if (load_i) begin
            tx_sr     <= tx_byte_i;
            tx_addr_o <= TXAW'(1);
            tx_take_o <= 1'b1;
            tx_bit    <= '0;
            rx_bit    <= '0;
            bit_cnt   <= '0;
            rx_idx    <= '0;
            miso_o    <= 1'b1;
         end else if (abort_i) begin
            tx_addr_o <= '0;
            miso_o    <= 1'b1;
         end else begin
            if (rise_i) begin
               miso_o <= tx_sr[7];
               tx_bit <= tx_bit + 3'd1;
               if (tx_bit == 3'd7) begin
                  if (fetch_ok) begin
                     tx_sr     <= tx_byte_i;
                     tx_take_o <= 1'b1;
                     tx_addr_o <= tx_addr_o + TXAW'(1);
                  end else begin
                     tx_sr <= 8'hFF;
                  end
               end else begin
                  tx_sr <= {tx_sr[6:0], 1'b1};
               end
            end
            if (fall_i) begin
               rx_sr   <= {rx_sr[6:0], mosi_i};
               rx_bit  <= rx_bit + 3'd1;
               bit_cnt <= bit_cnt + BITW'(1);
               if (rx_bit == 3'd7) begin
                  rx_byte_o  <= {rx_sr[6:0], mosi_i};
                  rx_valid_o <= 1'b1;
                  rx_addr_o  <= rx_idx;
                  rx_idx     <= rx_idx + RXAW'(1);
               end
               if (is_last) begin
                  last_o    <= 1'b1;
                  miso_o    <= 1'b1;
                  tx_addr_o <= '0;
               end
            end
         end
      end
   end

   // R2
   last_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> (rx_valid_o && rx_addr_o == RXAW'(FRAME_BYTES - 1)));
endmodule

// File: rtl/hsf_ctrl.sv
module hsf_ctrl import hsf_pkg::*; #(
   parameter  int SRDY_LOW_CYCLES = 4,
   parameter  int TIMEOUT_CYCLES  = 1024,
   localparam int TOW             = $clog2(TIMEOUT_CYCLES + 1),
   localparam int GAPW            = $clog2(SRDY_LOW_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mrdy_rise_i,
   input  logic tx_req_i,
   input  logic cont_i,
   input  logic sclk_rise_i,
   input  logic sclk_edge_i,
   input  logic last_i,
   output logic load_o,
   output logic abort_o,
   output logic xfer_en_o,
   output logic srdy_o,
   output logic done_o,
   output logic ok_o,
   output logic timeout_o
);
   hsf_state_e     state, state_d;
   logic [TOW-1:0]  to_cnt;
   logic [GAPW-1:0] gap_cnt;
   logic [GAPW-1:0] low_run;
   logic            seen;
   logic            aborted;
   logic            pend;
   logic            to_expire;
   logic            gap_done;

   assign to_expire = (to_cnt == TOW'(TIMEOUT_CYCLES - 1)) && !sclk_edge_i;
   assign gap_done  = gap_cnt == GAPW'(SRDY_LOW_CYCLES - 1);
   assign load_o    = state == ST_PREP;
   assign xfer_en_o = (state == ST_READY) || (state == ST_XFER);
   assign abort_o   = (state == ST_XFER) && !last_i && to_expire;

   always_comb begin
      state_d = state;
      case (state)
         ST_IDLE:  if (mrdy_rise_i || (tx_req_i && seen)) state_d = ST_PREP;
         ST_PREP:  state_d = ST_READY;
         ST_READY: if (sclk_rise_i) state_d = ST_XFER;
         ST_XFER:  if (last_i || to_expire) state_d = ST_GAP;
         ST_GAP:   if (gap_done)
                      state_d = (pend || mrdy_rise_i || (cont_i && !aborted)) ? ST_PREP : ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         srdy_o    <= 1'b0;
         done_o    <= 1'b0;
         ok_o      <= 1'b0;
         timeout_o <= 1'b0;
         to_cnt    <= '0;
         gap_cnt   <= '0;
         seen      <= 1'b0;
         aborted   <= 1'b0;
         pend      <= 1'b0;
      end else begin
         state     <= state_d;
         srdy_o    <= (state_d == ST_READY) || (state_d == ST_XFER);
         done_o    <= (state == ST_XFER) && (state_d == ST_GAP);
         ok_o      <= (state == ST_XFER) && last_i;
         timeout_o <= abort_o;
         to_cnt    <= (state != ST_XFER || sclk_edge_i) ? '0 : to_cnt + TOW'(1);
         gap_cnt   <= (state == ST_GAP) ? gap_cnt + GAPW'(1) : '0;
         if (state == ST_READY && sclk_rise_i) seen <= 1'b1;
         aborted   <= abort_o || (aborted && state == ST_GAP);
         pend      <= (state == ST_GAP) && (pend || mrdy_rise_i);
      end
   end

   // checker state: cycles slave-ready has been low, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 low_run <= GAPW'(SRDY_LOW_CYCLES);
      else if (srdy_o)                            low_run <= '0;
      else if (low_run != GAPW'(SRDY_LOW_CYCLES)) low_run <= low_run + GAPW'(1);
   end

   // R7
   srdy_low_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(srdy_o) |-> low_run >= GAPW'(SRDY_LOW_CYCLES));
   // R4
   srdy_drop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !srdy_o);
   // R6
   timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);
   // R6
   timeout_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (done_o && !ok_o));
endmodule

// File: rtl/hs_spi_slave_frame.sv
module hs_spi_slave_frame import hsf_pkg::*; #(
   parameter  int PAYLOAD_BYTES   = 2044,
   parameter  int TIMEOUT_CYCLES  = 1024,
   parameter  int SRDY_LOW_CYCLES = 4,
   parameter  int SYNC_STAGES     = 2,
   localparam int FRAME_BYTES     = HDR_BYTES + PAYLOAD_BYTES,
   localparam int TXAW            = $clog2(FRAME_BYTES + 1),
   localparam int RXAW            = $clog2(FRAME_BYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            spi_sclk_i,
   input  logic            spi_mosi_i,
   output logic            spi_miso_o,
   input  logic            mrdy_i,
   output logic            srdy_o,
   input  logic            tx_req_i,
   input  logic            cont_i,
   input  logic [7:0]      tx_byte_i,
   output logic [TXAW-1:0] tx_addr_o,
   output logic            tx_take_o,
   output logic [7:0]      rx_byte_o,
   output logic            rx_valid_o,
   output logic [RXAW-1:0] rx_addr_o,
   output logic            frame_done_o,
   output logic            frame_ok_o,
   output logic            timeout_o
);
   generate
      if (PAYLOAD_BYTES < 4 || (PAYLOAD_BYTES % 4) != 0) begin : g_bad_payload
         $error("hs_spi_slave_frame: PAYLOAD_BYTES must be a positive multiple of 4");
      end
      if (TIMEOUT_CYCLES < 8) begin : g_bad_timeout
         $error("hs_spi_slave_frame: TIMEOUT_CYCLES too small");
      end
      if (SRDY_LOW_CYCLES < 1) begin : g_bad_low
         $error("hs_spi_slave_frame: SRDY_LOW_CYCLES must be at least 1");
      end
   endgenerate

   logic [2:0] sync_q;
   logic       sclk_s, mosi_s, mrdy_s;
   logic       sclk_prev, mrdy_prev;
   logic       sclk_rise, sclk_fall, mrdy_rise;
   logic       load, abort, xfer_en, last;

   hsf_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({spi_sclk_i, spi_mosi_i, mrdy_i}),
      .sync_o  (sync_q)
   );

   assign {sclk_s, mosi_s, mrdy_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         mrdy_prev <= 1'b0;
      end else begin
         sclk_prev <= sclk_s;
         mrdy_prev <= mrdy_s;
      end
   end

   assign sclk_rise = sclk_s && !sclk_prev;
   assign sclk_fall = !sclk_s && sclk_prev;
   assign mrdy_rise = mrdy_s && !mrdy_prev;

   hsf_ctrl #(
      .SRDY_LOW_CYCLES (SRDY_LOW_CYCLES),
      .TIMEOUT_CYCLES  (TIMEOUT_CYCLES)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .mrdy_rise_i (mrdy_rise),
      .tx_req_i    (tx_req_i),
      .cont_i      (cont_i),
      .sclk_rise_i (sclk_rise),
      .sclk_edge_i (sclk_rise || sclk_fall),
      .last_i      (last),
      .load_o      (load),
      .abort_o     (abort),
      .xfer_en_o   (xfer_en),
      .srdy_o      (srdy_o),
      .done_o      (frame_done_o),
      .ok_o        (frame_ok_o),
      .timeout_o   (timeout_o)
   );

   hsf_datapath #(.FRAME_BYTES(FRAME_BYTES)) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .abort_i    (abort),
      .rise_i     (sclk_rise && xfer_en),
      .fall_i     (sclk_fall && xfer_en),
      .mosi_i     (mosi_s),
      .tx_byte_i  (tx_byte_i),
      .tx_addr_o  (tx_addr_o),
      .tx_take_o  (tx_take_o),
      .miso_o     (spi_miso_o),
      .rx_byte_o  (rx_byte_o),
      .rx_valid_o (rx_valid_o),
      .rx_addr_o  (rx_addr_o),
      .last_o     (last)
   );

   // R1
   miso_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !srdy_o |-> spi_miso_o);
endmodule

// File: tb/hs_spi_slave_frame_tb_top.sv
module hs_spi_slave_frame_tb_top;
   localparam int PAYLOAD = 4;
   localparam int FB      = 4 + PAYLOAD;
   localparam int NBITS   = FB * 8;
   localparam int TXAW    = $clog2(FB + 1);
   localparam int RXAW    = $clog2(FB);
   localparam int HALF    = 4;
   localparam int LOWMIN  = 4;
   // mosi seed [9:2], cont [1], drop master-ready mid-frame [0]
   localparam logic [9:0] VEC [4] = '{
      {8'hA5, 1'b1, 1'b0},
      {8'h3C, 1'b0, 1'b1},
      {8'h00, 1'b1, 1'b0},
      {8'hFF, 1'b0, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n, sclk, mosi, mrdy, tx_req, cont;
   logic miso, srdy, tx_take, rx_valid, done, ok, tmo;
   logic [7:0] tx_byte, rx_byte;
   logic [TXAW-1:0] tx_addr;
   logic [RXAW-1:0] rx_addr;

   int errors = 0, checks = 0, frame_no = 0;
   int rx_cnt = 0, done_ok = 0, done_bad = 0, to_cnt = 0;
   int low_cnt = 0, last_low = 0;
   bit fin = 1'b0;
   logic [7:0] rx_mem [FB];
   logic [7:0] mrx [FB];

   always #10 clk = ~clk;

   function automatic logic [7:0] txp(input int f, input int a);
      return 8'((f * 37 + a * 29 + 53) ^ (a << 1));
   endfunction
   function automatic logic [7:0] mp(input logic [7:0] s, input int a);
      return s ^ 8'(a * 71 + 13);
   endfunction

   assign tx_byte = txp(frame_no, int'(tx_addr));

   hs_spi_slave_frame #(
      .PAYLOAD_BYTES(PAYLOAD), .TIMEOUT_CYCLES(40),
      .SRDY_LOW_CYCLES(LOWMIN), .SYNC_STAGES(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sclk_i(sclk), .spi_mosi_i(mosi),
      .spi_miso_o(miso), .mrdy_i(mrdy), .srdy_o(srdy), .tx_req_i(tx_req),
      .cont_i(cont), .tx_byte_i(tx_byte), .tx_addr_o(tx_addr),
      .tx_take_o(tx_take), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid),
      .rx_addr_o(rx_addr), .frame_done_o(done), .frame_ok_o(ok),
      .timeout_o(tmo)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin rx_mem[rx_addr] = rx_byte; rx_cnt++; end
         if (done) begin if (ok) done_ok++; else done_bad++; end
         if (tmo) to_cnt++;
         if (!srdy) low_cnt++;
         else begin if (low_cnt > 0) last_low = low_cnt; low_cnt = 0; end
      end else low_cnt = 0;
   end

   task automatic check(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_bits(input int nbits, input logic [7:0] ms, input int drop_at);
      for (int b = 0; b < nbits; b++) begin
         @(negedge clk);
         sclk = 1'b1;
         mosi = mp(ms, b / 8)[7 - (b % 8)];
         if (b == drop_at) mrdy = 1'b0;
         repeat (HALF) @(negedge clk);
         mrx[b / 8][7 - (b % 8)] = miso;
         sclk = 1'b0;
         repeat (HALF - 1) @(negedge clk);
      end
   endtask

   task automatic check_bytes(input logic [7:0] ms, input int fno, input string tag);
      int bad_tx = -1, bad_rx = -1;
      for (int i = FB - 1; i >= 0; i--) begin
         if (mrx[i] !== txp(fno, i)) bad_tx = i;
         if (rx_mem[i] !== mp(ms, i)) bad_rx = i;
      end
      check(bad_tx < 0, {tag, " miso bytes (first bad index)"}, bad_tx, -1);
      check(bad_rx < 0, {tag, " mosi bytes (first bad index)"}, bad_rx, -1);
   endtask

   task automatic wait_srdy(input string tag);
      int n = 0;
      while (!srdy && n < 60) begin @(negedge clk); n++; end
      check(srdy == 1'b1, tag, int'(srdy), 1);
   endtask

   task automatic toggle_mrdy();
      mrdy = 1'b0;
      repeat (3) @(negedge clk);
      mrdy = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int b_ok, b_rx, b_bad, b_to;
      rst_n = 1'b0; sclk = 1'b0; mosi = 1'b1; mrdy = 1'b0; tx_req = 1'b0; cont = 1'b0;
      repeat (5) @(negedge clk);
      // R10 reset state
      check(srdy == 1'b0, "R10 srdy in reset", int'(srdy), 0);
      check(miso == 1'b1, "R10 miso in reset", int'(miso), 1);
      check(done == 1'b0 && tmo == 1'b0, "R10 strobes in reset", int'(done | tmo), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R8: local request before any master frame is ignored
      tx_req = 1'b1;
      repeat (20) @(negedge clk);
      check(srdy == 1'b0, "R8 tx_req before first master frame", int'(srdy), 0);
      tx_req = 1'b0;

      // vector table: frames with varied data, continue and mid-frame drop
      for (int v = 0; v < 4; v++) begin
         repeat (10) @(negedge clk);
         if (v > 0 && VEC[v-1][1]) begin
            check(srdy == 1'b1, "R4 re-raise on continue", int'(srdy), 1);
            check(last_low >= LOWMIN, "R7 slave-ready low time", last_low, LOWMIN);
         end else begin
            toggle_mrdy();
         end
         wait_srdy("R3 srdy after master-ready rise");
         cont = VEC[v][1];
         b_ok = done_ok; b_rx = rx_cnt;
         run_bits(NBITS, VEC[v][9:2], VEC[v][0] ? 20 : -1);
         frame_no++;
         repeat (8) @(negedge clk);
         check(done_ok == b_ok + 1, VEC[v][0] ? "R5 frame completes after mrdy drop" : "R2 done ok",
               done_ok - b_ok, 1);
         check(rx_cnt == b_rx + FB, "R2 received byte count", rx_cnt - b_rx, FB);
         check_bytes(VEC[v][9:2], frame_no - 1, "R1 R2");
         if (!VEC[v][1]) begin
            repeat (20) @(negedge clk);
            check(srdy == 1'b0, "R4 idle without continue", int'(srdy), 0);
            if (!VEC[v][0])
               check(srdy == 1'b0, "R3 mrdy level alone does not start", int'(srdy), 0);
            check(miso == 1'b1, "R1 miso idle high", int'(miso), 1);
         end
      end

      // R8: local request after a master frame starts a frame
      mrdy = 1'b0;
      repeat (5) @(negedge clk);
      tx_req = 1'b1;
      repeat (10) @(negedge clk);
      check(srdy == 1'b1, "R8 tx_req after first master frame", int'(srdy), 1);
      tx_req = 1'b0; cont = 1'b0;
      b_ok = done_ok;
      run_bits(NBITS, 8'h96, -1);
      frame_no++;
      repeat (8) @(negedge clk);
      check(done_ok == b_ok + 1, "R8 locally started frame done", done_ok - b_ok, 1);
      check_bytes(8'h96, frame_no - 1, "R8");

      // R6: stalled clock
      repeat (10) @(negedge clk);
      toggle_mrdy();
      wait_srdy("R6 srdy before stall");
      cont = 1'b1;
      b_bad = done_bad; b_to = to_cnt;
      run_bits(20, 8'h5A, -1);
      frame_no++;
      repeat (60) @(negedge clk);
      check(to_cnt == b_to + 1, "R6 single timeout pulse", to_cnt - b_to, 1);
      check(done_bad == b_bad + 1, "R6 done with fail flag", done_bad - b_bad, 1);
      check(srdy == 1'b0, "R6 srdy low after abort", int'(srdy), 0);
      check(miso == 1'b1, "R1 miso high after abort", int'(miso), 1);
      repeat (20) @(negedge clk);
      check(srdy == 1'b0, "R6 continue ignored after abort", int'(srdy), 0);
      cont = 1'b0;
      toggle_mrdy();
      wait_srdy("R6 srdy for recovery frame");
      b_ok = done_ok;
      run_bits(NBITS, 8'hC3, -1);
      frame_no++;
      repeat (8) @(negedge clk);
      check(done_ok == b_ok + 1, "R6 recovery frame done", done_ok - b_ok, 1);
      check_bytes(8'hC3, frame_no - 1, "R6 restart from byte 0");

      // R9: master-ready high while reset releases
      rst_n = 1'b0; mrdy = 1'b1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (12) @(negedge clk);
      check(srdy == 1'b1, "R9 start with mrdy high out of reset", int'(srdy), 1);

      fin = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule